// File: doc/BRIEF.md
# Digital Soft-Start Sequencer

This block paces the start-up of a switching regulator. It counts cycles of the switching clock. It begins only when the enable input and the supply-good input are both high. It first holds a digital reference code at zero for a fixed number of cycles. It then raises the code by one step per cycle until the code reaches full scale. After a short settling count, it reports power-good, but only while the output-voltage window comparator says the output is in range.

Along the way the block produces staged flags for the rest of the controller:
- a soft-start-active flag, high through the delay, ramp and settling phases;
- an undervoltage-check enable, which turns on once the code passes a set fraction of full scale;
- a low-side mask, which keeps the low-side switch off from the start of the sequence until the modulator reports its first PWM pulse.

A restart request, such as one raised by an undervoltage trip during start-up, sends the sequence back to the beginning of the delay with the code at zero. Dropping enable or supply-good abandons the sequence at once. The reference DAC and the error amplifier lie outside this block.

Top module: `softstart_seq`

## Requirements
- R1: After reset, and while `en_i` or `supply_ok_i` is low, the outputs are: `ref_code_o` = 0, `ss_active_o` = 0, `uv_en_o` = 0, `pgood_o` = 0, `ls_mask_o` = 1. A sequence starts on the first clock edge at which both inputs are high.
- R2: The first start edge begins an initial delay. The delay lasts exactly DELAY_CYCLES clock edges, during which `ref_code_o` stays 0 and `ss_active_o` is 1.
- R3: After the delay, `ref_code_o` increases by exactly 1 on every clock edge, starting at 0. It reaches 2^REF_W-1 after 2^REF_W-1 edges and then holds that value.
- R4: `uv_en_o` is 1 exactly when the sequence has left the initial delay and `ref_code_o` >= ceil((2^REF_W-1)*UV_PCT/100).
- R5: PG_DELAY clock edges after `ref_code_o` first reaches full scale, the sequence completes. At that point `ss_active_o` falls and `pgood_o` is allowed to assert. For a clean start this is 1+DELAY_CYCLES+(2^REF_W-1)+PG_DELAY edges after the start edge.
- R6: `ls_mask_o` is 1 from the start of a sequence. It falls on the edge after the first edge at which `pwm_first_i` is sampled high outside idle. It then stays 0 until a restart or a return to idle.
- R7: `restart_i` sampled high with `en_i` and `supply_ok_i` high puts the sequencer back at the start of the initial delay: `ref_code_o` = 0, `ss_active_o` = 1, `ls_mask_o` = 1, and a full DELAY_CYCLES delay follows. A restart takes priority over `pwm_first_i` on the same edge.
- R8: When `en_i` or `supply_ok_i` is low, `pgood_o` is 0 in the same cycle, with no clock edge needed. On the next edge the sequencer is in idle with the R1 outputs.
- R9: Once the sequence has completed, `pgood_o` equals `win_ok_i` combinationally. It drops in the same cycle the window is left and returns when the window is re-entered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Switching clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Enable, high to run |
| supply_ok_i | input | 1 | Both supplies above their lockout thresholds |
| restart_i | input | 1 | Restart the sequence from the initial delay |
| win_ok_i | input | 1 | Output voltage inside the power-good window |
| pwm_first_i | input | 1 | Modulator has issued a PWM pulse |
| ref_code_o | output | REF_W | Digital reference code |
| ss_active_o | output | 1 | Soft-start in progress |
| uv_en_o | output | 1 | Undervoltage checking enabled |
| ls_mask_o | output | 1 | Hold the low-side switch off |
| pgood_o | output | 1 | Power-good |

## Verification
The bench builds the sequencer with DELAY_CYCLES = 20, REF_W = 5, PG_DELAY = 3 and UV_PCT = 80. With these values a full sequence takes 55 cycles instead of more than two thousand. Random drops of enable, restarts and window exits therefore land in every phase many times: during the delay, at the undervoltage threshold (code 25), on the last ramp step, and during the settling count. The small code width also makes the full-scale hold and the ceiling in the threshold calculation show up in every run.

// File: rtl/ss_pkg.sv
package ss_pkg;
   typedef enum logic [2:0] {
      SS_IDLE   = 3'd0,
      SS_WAIT   = 3'd1,
      SS_RAMP   = 3'd2,
      SS_SETTLE = 3'd3,
      SS_RUN    = 3'd4
   } ss_state_e;

   function automatic int unsigned ss_uv_thresh(input int unsigned full, input int unsigned pct);
      return (full * pct + 99) / 100;
   endfunction
endpackage

// File: rtl/ss_cycle_counter.sv
module ss_cycle_counter #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr_i,
   input  logic             inc_i,
   output logic [CNT_W-1:0] cnt_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt_o <= '0;
      else if (clr_i)  cnt_o <= '0;
      else if (inc_i)  cnt_o <= cnt_o + 1'b1;
   end
endmodule

// File: rtl/ss_ref_ramp.sv
module ss_ref_ramp #(
   parameter int REF_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             zero_i,
   input  logic             step_i,
   output logic [REF_W-1:0] ref_o,
   output logic             full_o
);
   localparam logic [REF_W-1:0] REF_TOP = '1;

   assign full_o = (ref_o == REF_TOP);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 ref_o <= '0;
      else if (zero_i)            ref_o <= '0;
      else if (step_i && !full_o) ref_o <= ref_o + 1'b1;
   end
endmodule

// File: rtl/ss_mask_flag.sv
module ss_mask_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic mask_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      mask_o <= 1'b1;
      else if (set_i)  mask_o <= 1'b1;
      else if (clr_i)  mask_o <= 1'b0;
   end
endmodule

// File: rtl/softstart_seq.sv
module softstart_seq
   import ss_pkg::*;
#(
   parameter int DELAY_CYCLES = 1024,
   parameter int REF_W        = 10,
   parameter int PG_DELAY     = 3,
   parameter int UV_PCT       = 80
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en_i,
   input  logic             supply_ok_i,
   input  logic             restart_i,
   input  logic             win_ok_i,
   input  logic             pwm_first_i,
   output logic [REF_W-1:0] ref_code_o,
   output logic             ss_active_o,
   output logic             uv_en_o,
   output logic             ls_mask_o,
   output logic             pgood_o
);
   localparam int REF_MAX = (1 << REF_W) - 1;
   localparam int UV_TH   = int'(ss_uv_thresh(REF_MAX, UV_PCT));
   localparam int CNT_MAX = (DELAY_CYCLES > PG_DELAY) ? DELAY_CYCLES : PG_DELAY;
   localparam int CNT_W   = (CNT_MAX < 2) ? 1 : $clog2(CNT_MAX + 1);

   localparam logic [CNT_W-1:0] DELAY_LAST = CNT_W'(DELAY_CYCLES - 1);
   localparam logic [CNT_W-1:0] PG_LAST    = CNT_W'((PG_DELAY > 0) ? PG_DELAY - 1 : 0);
   localparam logic [REF_W-1:0] REF_PRE    = REF_W'(REF_MAX - 1);
   localparam logic [REF_W:0]   UV_TH_V    = (REF_W + 1)'(UV_TH);

   if (DELAY_CYCLES < 1) begin : g_bad_delay
      $error("softstart_seq: DELAY_CYCLES must be at least 1");
   end
   if (REF_W < 2 || REF_W > 16) begin : g_bad_width
      $error("softstart_seq: REF_W must lie in 2..16");
   end
   if (PG_DELAY < 0) begin : g_bad_pg
      $error("softstart_seq: PG_DELAY must not be negative");
   end
   if (UV_PCT < 0 || UV_PCT > 100) begin : g_bad_uv
      $error("softstart_seq: UV_PCT must lie in 0..100");
   end

   ss_state_e        st_q, st_d, ramp_exit;
   logic             run_ok, start_seq;
   logic [CNT_W-1:0] cnt;
   logic             cnt_clr, cnt_inc;
   logic             ref_zero, ref_step, ref_full;
   logic             mask_set, mask_clr;

   assign run_ok    = en_i & supply_ok_i;
   assign start_seq = run_ok & ((st_q == SS_IDLE) | restart_i);

   // the settling phase exists only when a power-good delay is asked for
   if (PG_DELAY > 0) begin : g_settle
      assign ramp_exit = SS_SETTLE;
   end else begin : g_no_settle
      assign ramp_exit = SS_RUN;
   end

   always_comb begin
      st_d = st_q;
      if (!run_ok) begin
         st_d = SS_IDLE;
      end else if (start_seq) begin
         st_d = SS_WAIT;
      end else begin
         unique case (st_q)
            SS_WAIT:   if (cnt == DELAY_LAST)        st_d = SS_RAMP;
            SS_RAMP:   if (ref_code_o == REF_PRE)    st_d = ramp_exit;
            SS_SETTLE: if (cnt == PG_LAST)           st_d = SS_RUN;
            SS_RUN:                                  st_d = SS_RUN;
            default:                                 st_d = SS_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= SS_IDLE;
      else        st_q <= st_d;
   end

   assign cnt_clr = (st_d != st_q) | start_seq;
   assign cnt_inc = (st_q == SS_WAIT) | (st_q == SS_SETTLE);

   ss_cycle_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .clr_i (cnt_clr),
      .inc_i (cnt_inc),
      .cnt_o (cnt)
   );

   assign ref_zero = ~run_ok | start_seq;
   assign ref_step = (st_q == SS_RAMP);

   ss_ref_ramp #(.REF_W(REF_W)) u_ramp (
      .clk    (clk),
      .rst_n  (rst_n),
      .zero_i (ref_zero),
      .step_i (ref_step),
      .ref_o  (ref_code_o),
      .full_o (ref_full)
   );

   assign mask_set = ~run_ok | start_seq;
   assign mask_clr = pwm_first_i & (st_q != SS_IDLE);

   ss_mask_flag u_mask (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (mask_set),
      .clr_i  (mask_clr),
      .mask_o (ls_mask_o)
   );

   assign ss_active_o = (st_q == SS_WAIT) | (st_q == SS_RAMP) | (st_q == SS_SETTLE);
   assign uv_en_o     = ((st_q == SS_RAMP) | (st_q == SS_SETTLE) | (st_q == SS_RUN))
                        & ({1'b0, ref_code_o} >= UV_TH_V);
   assign pgood_o     = (st_q == SS_RUN) & ref_full & win_ok_i & run_ok;
endmodule

// File: rtl/ss_seq_checker.sv
module ss_seq_checker #(
   parameter int REF_W  = 10,
   parameter int UV_PCT = 80
) (
   input logic             clk,
   input logic             rst_n,
   input logic             en_i,
   input logic             supply_ok_i,
   input logic             restart_i,
   input logic             win_ok_i,
   input logic             pwm_first_i,
   input logic [REF_W-1:0] ref_code_o,
   input logic             ss_active_o,
   input logic             uv_en_o,
   input logic             ls_mask_o,
   input logic             pgood_o
);
   localparam logic [REF_W-1:0] FULL = '1;
   localparam int               THR  = int'(ss_pkg::ss_uv_thresh((1 << REF_W) - 1, UV_PCT));

   AST_IDLE_AFTER_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      !(en_i && supply_ok_i) |=> (ref_code_o == '0 && !ss_active_o && !uv_en_o && ls_mask_o)); // R8

   AST_PGOOD_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
      pgood_o |-> (en_i && supply_ok_i)); // R8

   AST_RAMP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (ss_active_o && ref_code_o != '0 && ref_code_o != FULL && en_i && supply_ok_i && !restart_i)
      |=> (ref_code_o == $past(ref_code_o) + 1'b1)); // R3

   AST_UV_THRESHOLD: assert property (@(posedge clk) disable iff (!rst_n)
      uv_en_o |-> (int'(ref_code_o) >= THR)); // R4

   AST_PGOOD_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      pgood_o |-> (ref_code_o == FULL && !ss_active_o)); // R5

   AST_PGOOD_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
      pgood_o |-> win_ok_i); // R9

   AST_MASK_STAYS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (!ls_mask_o && en_i && supply_ok_i && !restart_i) |=> !ls_mask_o); // R6

   AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (restart_i && en_i && supply_ok_i) |=> (ref_code_o == '0 && ss_active_o && ls_mask_o)); // R7
endmodule

bind softstart_seq ss_seq_checker #(.REF_W(REF_W), .UV_PCT(UV_PCT)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .en_i        (en_i),
   .supply_ok_i (supply_ok_i),
   .restart_i   (restart_i),
   .win_ok_i    (win_ok_i),
   .pwm_first_i (pwm_first_i),
   .ref_code_o  (ref_code_o),
   .ss_active_o (ss_active_o),
   .uv_en_o     (uv_en_o),
   .ls_mask_o   (ls_mask_o),
   .pgood_o     (pgood_o)
);

// File: tb/softstart_seq_tb.sv
module softstart_seq_tb;
   localparam int DLY = 20;
   localparam int RW  = 5;
   localparam int PGD = 3;
   localparam int UVP = 80;
   localparam int FULL = (1 << RW) - 1;

   logic clk = 1'b0, rst_n = 1'b0;
   logic en = 1'b0, sok = 1'b0, rs = 1'b0, win = 1'b0, pwm = 1'b0;
   logic [RW-1:0] ref_code;
   logic ss_act, uv_en, ls_mask, pg;

   int checks = 0, fails = 0;
   bit done = 1'b0;

   // model state: 0 idle, 1 delay, 2 ramp, 3 settle, 4 complete
   int m_st = 0, m_cnt = 0, m_ref = 0;
   bit m_mask = 1'b1;

   always #2.5 clk = ~clk;

   softstart_seq #(.DELAY_CYCLES(DLY), .REF_W(RW), .PG_DELAY(PGD), .UV_PCT(UVP)) u_dut (
      .clk(clk), .rst_n(rst_n), .en_i(en), .supply_ok_i(sok), .restart_i(rs),
      .win_ok_i(win), .pwm_first_i(pwm), .ref_code_o(ref_code), .ss_active_o(ss_act),
      .uv_en_o(uv_en), .ls_mask_o(ls_mask), .pgood_o(pg)
   );

   function automatic int uv_thr();
      return (FULL * UVP + 99) / 100;
   endfunction

   function automatic int exp_uv();
      return (m_st >= 2 && m_ref >= uv_thr()) ? 1 : 0;
   endfunction

   function automatic int exp_pg();
      return (m_st == 4 && win && en && sok) ? 1 : 0;
   endfunction

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s at %0t: actual %0d expected %0d", tag, $time, act, exp);
      end
   endtask

   task automatic check_all();
      chk("R3 reference code", int'(ref_code), m_ref);
      chk("R2 soft-start active", int'(ss_act), (m_st >= 1 && m_st <= 3) ? 1 : 0);
      chk("R4 undervoltage enable", int'(uv_en), exp_uv());
      chk("R6 low-side mask", int'(ls_mask), int'(m_mask));
      chk("R9 power-good", int'(pg), exp_pg());
   endtask

   task automatic model_step();
      if (!(en && sok)) begin
         m_st = 0; m_cnt = 0; m_ref = 0; m_mask = 1'b1;
      end else if (m_st == 0 || rs) begin
         m_st = 1; m_cnt = 0; m_ref = 0; m_mask = 1'b1;
      end else begin
         if (pwm) m_mask = 1'b0;
         case (m_st)
            1: if (m_cnt == DLY - 1) begin m_st = 2; m_cnt = 0; end else m_cnt++;
            2: begin
                  if (m_ref == FULL - 1) begin m_st = (PGD > 0) ? 3 : 4; m_cnt = 0; end
                  if (m_ref < FULL) m_ref++;
               end
            3: if (m_cnt == PGD - 1) begin m_st = 4; m_cnt = 0; end else m_cnt++;
            default: ;
         endcase
      end
   endtask

   // drive inputs just after a falling edge, check, then advance one clock
   task automatic cyc(input bit e, input bit s, input bit r, input bit w, input bit p);
      en = e; sok = s; rs = r; win = w; pwm = p;
      #1;
      check_all();
      @(posedge clk);
      model_step();
      @(negedge clk);
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!done) begin
         fails++; checks++;
         $display("FAIL watchdog expired");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin : stim
      int n;
      bit seen;
      void'($urandom(32'h5eed_0041));
      repeat (3) @(negedge clk);
      #1;
      chk("R1 reset ref", int'(ref_code), 0);
      chk("R1 reset mask", int'(ls_mask), 1);
      chk("R1 reset pgood", int'(pg), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: only one of the two start conditions present -> stays idle
      repeat (5) cyc(1, 0, 0, 1, 0);
      repeat (5) cyc(0, 1, 0, 1, 0);
      chk("R1 idle with one input low", int'(ss_act), 0);

      // R5: clean start, count edges until power-good
      n = 0; seen = 1'b0;
      while (!seen && n < 200) begin
         cyc(1, 1, 0, 1, (n == DLY + 4) ? 1'b1 : 1'b0);
         n++;
         #1;
         if (pg) seen = 1'b1;
      end
      chk("R5 edges to power-good", n, 1 + DLY + FULL + PGD);
      chk("R6 mask cleared after pulse", int'(ls_mask), 0);

      // R9: window exit and return after completion
      cyc(1, 1, 0, 0, 0);
      cyc(1, 1, 0, 1, 0);
      chk("R9 pgood back with window", int'(pg), 1);

      // R7: restart from the completed state, pulse on same edge loses
      cyc(1, 1, 1, 1, 1);
      chk("R7 ref zero after restart", int'(ref_code), 0);
      chk("R7 mask set after restart", int'(ls_mask), 1);
      repeat (DLY + 10) cyc(1, 1, 0, 1, 0);
      cyc(1, 1, 1, 1, 0);
      chk("R7 restart mid ramp ref", int'(ref_code), 0);
      chk("R7 restart mid ramp active", int'(ss_act), 1);

      // R8: run to completion, then drop supply-good
      repeat (DLY + FULL + PGD + 2) cyc(1, 1, 0, 1, 0);
      en = 1'b1; sok = 1'b0; #1;
      chk("R8 pgood drops same cycle", int'(pg), 0);
      cyc(1, 0, 0, 1, 0);
      chk("R8 idle after drop", int'(ss_act), 0);
      chk("R8 ref cleared", int'(ref_code), 0);

      // constrained random mix
      for (int i = 0; i < 8000; i++) begin
         bit e, s, r, w, p;
         e = ($urandom_range(0, 249) != 0);
         s = ($urandom_range(0, 299) != 0);
         r = ($urandom_range(0, 179) == 0);
         w = ($urandom_range(0, 19) != 0);
         p = ($urandom_range(0, 29) == 0);
         cyc(e, s, r, w, p);
      end

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule